// File: doc/BRIEF.md
# Core Interrupt Latch Controller

This block keeps the latch and mask state for the sixteen event levels of a processor core's event controller. A hardware event request pulse sets its latch bit. The bit then stays set until the core takes that event. Bits 7 to 15 are general interrupt levels, bit 6 is the core timer and bit 5 is the hardware error event. From the latched bits that are also enabled in the mask, the block offers one event number to the sequencer. When the sequencer acknowledges it, the block clears that latch bit and sets the matching pending bit on the same clock edge.

Software reaches the latch and the mask through a small register port that carries a privilege input. On the latch, software can only cancel. A supervisor write-one-to-clear removes a latched request, but only for a request whose mask bit is already 0. A separate raise request sets one chosen latch bit from a fixed set of raisable levels. Bit 0 survives all software and acknowledge activity, and only the test-reset input clears it. The sequencer releases pending bits through a clear vector.

Top module: `evt_latch_ctrl`

## Requirements
- R1: After reset the latch reads 0x0000001F, the mask reads 0 and the pending vector is 0.
- R2: A 1 on evt_req[N] sets latch bit N on the next clock edge, and the bit then holds until something clears it.
- R3: acc_vld is 1 only when some bit N is latched, has mask bit N equal to 1, and has no pending bit at a number of N or lower. acc_num is the lowest such N.
- R4: An acc_ack while acc_vld is 1 clears latch bit acc_num and sets pending bit acc_num on the same edge. A 1 in pend_clr[N] clears pending bit N, and a pending set wins over a pending clear of the same bit in the same cycle.
- R5: A write with reg_sel=0 and reg_super=1 clears each latch bit N (N>=1) that has a 1 in reg_wdata[N] and mask bit N equal to 0. Data bits whose mask bit is 1 leave the latch unchanged.
- R6: With reg_super=0, writes to either register are ignored, and reads still return the register contents.
- R7: reg_rdata returns the latch when reg_sel=0 and the mask when reg_sel=1, combinationally. Bits 16 to 31 always read 0, and write data in those bits is dropped.
- R8: raise_vld with raise_num=N sets latch bit N on the next edge for N in {1,2,5..15}. For N in {0,3,4} it has no effect.
- R9: Latch bit 0 is not cleared by a software clear or by an acknowledge. A 1 on tst_clr clears it on the next edge.
- R10: When a set (event or raise) and a clear of the same latch bit occur in one cycle, the bit ends up set.
- R11: A write with reg_sel=1 and reg_super=1 loads the mask from reg_wdata[15:0]. A mask bit of 1 enables an event and 0 masks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tst_clr | input | 1 | Test-reset; clears latch bit 0 |
| evt_req | input | 16 | Hardware event request pulses, one per level |
| raise_vld | input | 1 | Software raise request strobe |
| raise_num | input | 4 | Level number to raise |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = latch register, 1 = mask register |
| reg_super | input | 1 | 1 = access made in supervisor mode |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| acc_vld | output | 1 | An event is offered to the sequencer |
| acc_num | output | 4 | Number of the offered event |
| acc_ack | input | 1 | Sequencer accepts the offered event |
| pend_clr | input | 16 | Pending-bit clear vector from the sequencer |
| pend | output | 16 | Pending vector |

## Verification
The selection is tried in a sweep of forty computed pairs of latch pattern and mask pattern. This sweep tells a lowest-number pick from a highest-number pick, and it tells mask gating from no gating. Acknowledge sequences with lower- and higher-numbered arrivals check that a pending level blocks only levels at its own number or above. The raise input is swept over all sixteen numbers, which tells the raisable levels from the refused ones. Clears are tried with the mask bit at 0 and at 1, in user and supervisor mode, and together with a new event on the same bit, which tells each gate of the cancel path apart.

// File: rtl/evt_latch_pkg.sv
package evt_latch_pkg;
   typedef enum logic {
      SEL_LAT = 1'b0,
      SEL_MSK = 1'b1
   } reg_sel_e;

   localparam int unsigned DEF_NUM_EVT = 16;
   localparam int unsigned DEF_REG_W   = 32;
endpackage

// File: rtl/evt_lat_cell.sv
module evt_lat_cell #(
   parameter logic RST_V = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= RST_V;
      else        q_o <= set_i | (q_o & ~clr_i);
   end

   // R10: a set wins over a simultaneous clear
   p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   // R2: with no set and no clear the bit holds
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/evt_prio_pick.sv
module evt_prio_pick #(
   parameter int unsigned N     = 16,
   parameter int unsigned STYLE = 0,
   localparam int unsigned IW   = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic          vld_o,
   output logic [IW-1:0] idx_o
);
   assign vld_o = |req_i;

   if (STYLE == 0) begin : g_scan
      always_comb begin
         idx_o = '0;
         for (int i = N - 1; i >= 0; i--)
            if (req_i[i]) idx_o = IW'(i);
      end
   end else begin : g_isolate
      logic [N-1:0] one_hot;
      assign one_hot = req_i & (~req_i + N'(1));
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < N; i++)
            if (one_hot[i]) idx_o = idx_o | IW'(i);
      end
   end
endmodule

// File: rtl/evt_latch_ctrl.sv
module evt_latch_ctrl
   import evt_latch_pkg::*;
#(
   parameter int unsigned NUM_EVT    = DEF_NUM_EVT,
   parameter int unsigned REG_W      = DEF_REG_W,
   parameter logic [NUM_EVT-1:0] RST_LAT  = NUM_EVT'('h1F),
   parameter logic [NUM_EVT-1:0] RAISE_OK = NUM_EVT'('hFFE6),
   parameter int unsigned PICK_STYLE = 0,
   localparam int unsigned IW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tst_clr,
   input  logic [NUM_EVT-1:0] evt_req,
   input  logic               raise_vld,
   input  logic [IW-1:0]      raise_num,
   input  logic               reg_wr,
   input  logic               reg_sel,
   input  logic               reg_super,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   output logic               acc_vld,
   output logic [IW-1:0]      acc_num,
   input  logic               acc_ack,
   input  logic [NUM_EVT-1:0] pend_clr,
   output logic [NUM_EVT-1:0] pend
);
   initial begin : elab_chk
      if (NUM_EVT < 2 || NUM_EVT > REG_W)
         $fatal(1, "evt_latch_ctrl: NUM_EVT must lie in 2..REG_W");
      if (PICK_STYLE > 1)
         $fatal(1, "evt_latch_ctrl: PICK_STYLE must be 0 or 1");
   end

   logic [NUM_EVT-1:0] lat, msk, set_v, clr_v, ack_v, pre_p, elig;
   logic lat_wr, msk_wr;

   assign lat_wr = reg_wr && reg_super && (reg_sel_e'(reg_sel) == SEL_LAT);
   assign msk_wr = reg_wr && reg_super && (reg_sel_e'(reg_sel) == SEL_MSK);

   if (REG_W > NUM_EVT) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^reg_wdata[REG_W-1:NUM_EVT];
   end

   for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_bit
      logic rs_hit, ack_hit, sw_hit;
      assign rs_hit  = raise_vld && (raise_num == IW'(gi)) && RAISE_OK[gi];
      assign ack_hit = acc_vld && acc_ack && (acc_num == IW'(gi));
      assign sw_hit  = lat_wr && reg_wdata[gi] && !msk[gi];
      assign set_v[gi] = evt_req[gi] | rs_hit;
      assign ack_v[gi] = ack_hit;
      if (gi == 0) begin : g_sticky
         assign clr_v[gi] = tst_clr;
      end else begin : g_norm
         assign clr_v[gi] = ack_hit | sw_hit;
      end
      evt_lat_cell #(.RST_V(RST_LAT[gi])) u_cell (
         .clk(clk), .rst_n(rst_n), .set_i(set_v[gi]),
         .clr_i(clr_v[gi]), .q_o(lat[gi]));
      if (gi == 0) begin : g_p0
         assign pre_p[gi] = pend[gi];
      end else begin : g_pn
         assign pre_p[gi] = pre_p[gi-1] | pend[gi];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msk  <= '0;
         pend <= '0;
      end else begin
         if (msk_wr) msk <= reg_wdata[NUM_EVT-1:0];
         pend <= (pend & ~pend_clr) | ack_v;
      end
   end

   assign elig = lat & msk & ~pre_p;

   evt_prio_pick #(.N(NUM_EVT), .STYLE(PICK_STYLE)) u_pick (
      .req_i(elig), .vld_o(acc_vld), .idx_o(acc_num));

   always_comb begin
      reg_rdata = '0;
      reg_rdata[NUM_EVT-1:0] = (reg_sel_e'(reg_sel) == SEL_MSK) ? msk : lat;
   end

   // R3: the offered event is latched, enabled and not yet pending
   p_pick_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_vld |-> (lat[acc_num] && msk[acc_num] && !pend[acc_num]));
   // R4: acknowledge marks the event pending on the next cycle
   p_ack_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && acc_ack) |=> pend[$past(acc_num)]);
   // R6: user-mode writes leave the mask unchanged
   p_mask_user_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_super) |=> (msk == $past(msk)));
   // R9: bit 0 only falls after tst_clr
   p_bit0_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (lat[0] && !tst_clr) |=> lat[0]);
endmodule

// File: tb/sim_evt_latch_ctrl.sv
module sim_evt_latch_ctrl;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tst_clr = 1'b0;
   logic [15:0] evt_req = '0;
   logic        raise_vld = 1'b0;
   logic [3:0]  raise_num = '0;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic        reg_super = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        acc_vld;
   logic [3:0]  acc_num;
   logic        acc_ack = 1'b0;
   logic [15:0] pend_clr = '0;
   logic [15:0] pend;

   int checks = 0;
   int fails  = 0;

   evt_latch_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .tst_clr(tst_clr), .evt_req(evt_req),
      .raise_vld(raise_vld), .raise_num(raise_num), .reg_wr(reg_wr),
      .reg_sel(reg_sel), .reg_super(reg_super), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .acc_vld(acc_vld), .acc_num(acc_num),
      .acc_ack(acc_ack), .pend_clr(pend_clr), .pend(pend));

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic sel, input logic sup, input logic [31:0] d);
      reg_wr = 1'b1; reg_sel = sel; reg_super = sup; reg_wdata = d;
      cyc();
      reg_wr = 1'b0; reg_super = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic sel, output logic [31:0] d);
      reg_sel = sel; #1; d = reg_rdata;
   endtask

   task automatic evt(input logic [15:0] p);
      evt_req = p; cyc(); evt_req = '0;
   endtask

   task automatic ack();
      acc_ack = 1'b1; cyc(); acc_ack = 1'b0;
   endtask

   function automatic int lowest(input logic [15:0] v);
      for (int i = 0; i < 16; i++) if (v[i]) return i;
      return 0;
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      logic [15:0] p, m, e;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state, R7 read selection
      rd(1'b0, d); chk("R1 latch reset", d, 32'h1F);
      rd(1'b1, d); chk("R1 mask reset", d, 32'h0);
      chk("R1 pend reset", {16'h0, pend}, 32'h0);
      chk("R1 no offer", {31'h0, acc_vld}, 32'h0);
      // R6 user-mode writes ignored, reads allowed
      wr(1'b1, 1'b0, 32'hFFFF);
      rd(1'b1, d); chk("R6 user mask write", d, 32'h0);
      wr(1'b0, 1'b0, 32'h1E);
      rd(1'b0, d); chk("R6 user latch clear", d, 32'h1F);
      // R5 supervisor clear with mask 0; R9 bit 0 survives
      wr(1'b0, 1'b1, 32'hFFFF_FFFE);
      rd(1'b0, d); chk("R5 clear masked", d, 32'h1);
      wr(1'b0, 1'b1, 32'h1);
      rd(1'b0, d); chk("R9 sw clear bit0", d, 32'h1);
      tst_clr = 1'b1; cyc(); tst_clr = 1'b0;
      rd(1'b0, d); chk("R9 tst_clr", d, 32'h0);
      // R11 mask write, R7 upper bits dropped
      wr(1'b1, 1'b1, 32'hFFFF_0020);
      rd(1'b1, d); chk("R11 R7 mask load", d, 32'h20);
      wr(1'b1, 1'b1, 32'h0);
      // R8 raise sweep
      for (int n = 0; n < 16; n++) begin
         raise_vld = 1'b1; raise_num = 4'(n); cyc(); raise_vld = 1'b0;
         e = (n == 0 || n == 3 || n == 4) ? 16'h0 : (16'h1 << n);
         rd(1'b0, d); chk($sformatf("R8 raise %0d", n), d, {16'h0, e});
         wr(1'b0, 1'b1, 32'hFFFE);
      end
      // R5 clear ignored when enabled
      wr(1'b1, 1'b1, 32'hFFFF);
      raise_vld = 1'b1; raise_num = 4'd5; cyc(); raise_vld = 1'b0;
      chk("R3 offer raised", {27'h0, acc_vld, acc_num}, {27'h0, 1'b1, 4'd5});
      wr(1'b0, 1'b1, 32'h20);
      rd(1'b0, d); chk("R5 clear enabled ignored", d, 32'h20);
      // R3 R2 sweep over latch/mask patterns
      for (int k = 1; k <= 40; k++) begin
         p = 16'(k * 16'h9E37) ^ 16'(k << 3);
         p = p & 16'hFFFE;
         if (p == 0) p = 16'h2;
         m = ~16'(k * 16'h3B1D);
         wr(1'b1, 1'b1, 32'h0);
         wr(1'b0, 1'b1, 32'hFFFE);
         evt(p);
         rd(1'b0, d); chk("R2 event latched", d, {16'h0, p});
         wr(1'b1, 1'b1, {16'h0, m});
         e = p & m;
         chk($sformatf("R3 sweep vld k=%0d", k), {31'h0, acc_vld}, {31'h0, |e});
         if (|e)
            chk($sformatf("R3 sweep num k=%0d", k), {28'h0, acc_num}, 32'(lowest(e)));
      end
      // R4 acknowledge and pending blocking
      wr(1'b1, 1'b1, 32'h0);
      wr(1'b0, 1'b1, 32'hFFFE);
      evt(16'h0120);
      repeat (3) cyc();
      rd(1'b0, d); chk("R2 hold", d, 32'h120);
      wr(1'b1, 1'b1, 32'hFFFF);
      chk("R3 pick 5", {27'h0, acc_vld, acc_num}, {27'h0, 1'b1, 4'd5});
      ack();
      rd(1'b0, d); chk("R4 latch cleared", d, 32'h100);
      chk("R4 pend set", {16'h0, pend}, 32'h20);
      chk("R3 blocked by pend", {31'h0, acc_vld}, 32'h0);
      evt(16'h0008);
      chk("R3 lower preempts", {27'h0, acc_vld, acc_num}, {27'h0, 1'b1, 4'd3});
      ack();
      chk("R4 nested pend", {16'h0, pend}, 32'h28);
      pend_clr = 16'h0028; cyc(); pend_clr = '0;
      chk("R4 pend_clr", {16'h0, pend}, 32'h0);
      chk("R3 pick 8", {27'h0, acc_vld, acc_num}, {27'h0, 1'b1, 4'd8});
      // R10 event beats acknowledge clear
      acc_ack = 1'b1; evt_req = 16'h0100; cyc(); acc_ack = 1'b0; evt_req = '0;
      rd(1'b0, d); chk("R10 ack vs event", d, 32'h100);
      chk("R4 pend 8", {16'h0, pend}, 32'h100);
      pend_clr = 16'h0100; cyc(); pend_clr = '0;
      wr(1'b1, 1'b1, 32'h0);
      reg_wr = 1'b1; reg_sel = 1'b0; reg_super = 1'b1; reg_wdata = 32'h200;
      evt_req = 16'h0200; cyc();
      reg_wr = 1'b0; reg_super = 1'b0; reg_wdata = '0; evt_req = '0;
      rd(1'b0, d); chk("R10 clear vs event", d, 32'h300);
      // R9 bit 0 under acknowledge
      wr(1'b0, 1'b1, 32'hFFFE);
      evt(16'h0001);
      wr(1'b0, 1'b1, 32'hFFFF);
      rd(1'b0, d); chk("R9 bit0 kept", d, 32'h1);
      wr(1'b1, 1'b1, 32'h1);
      chk("R3 pick 0", {27'h0, acc_vld, acc_num}, {27'h0, 1'b1, 4'd0});
      ack();
      rd(1'b0, d); chk("R9 ack keeps bit0", d, 32'h1);
      chk("R4 pend 0", {16'h0, pend}, 32'h1);
      tst_clr = 1'b1; cyc(); tst_clr = 1'b0;
      rd(1'b0, d); chk("R9 tst_clr again", d, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule